// File: doc/BRIEF.md
# Windowed LMS Coefficient Updater

This block adapts the short coefficient window of an echo-cancelling FIR after each output sample. An upstream filter pass has already produced an output and the error against the desired signal. The block then receives one signed constant: the step size already multiplied by that error. For every window tap it fetches the stored coefficient and the history sample paired with it. It forms the coefficient plus the constant times the sample, rounds and saturates the result, and writes it back in place.

The history is a circular buffer of N samples addressed by a write offset f. The window of M coefficients sits at a bulk delay d inside the full echo tail. Tap k pairs with history slot (f − d + N − 1 − k) mod N. The read index therefore counts down and wraps from slot 0 to slot N − 1 when the window straddles the end of the buffer. Both memories are external with one-cycle read latency. The block drives a shared read enable, the two read addresses and a coefficient write port. It processes one tap per cycle, and a `done` pulse marks the last write.

Top module: `wlms_coef_update`

## Requirements
- R1: After reset, `busy`, `done`, `mem_rd_en` and `coef_we` are all low.
- R2: The value written for tap k is sat(h[k] + ((c·x + 2^(FRAC−1)) >> FRAC)), with an arithmetic shift, c = `step_err_i` and FRAC = 15 by default.
- R3: The history address for tap 0 is (f − d + N − 1) mod N. It decreases by one per tap and wraps from 0 to N − 1. This holds for every f in 0..N−1 and d in 0..N−M.
- R4: Results outside the signed CW-bit range are clamped to −2^(CW−1) or 2^(CW−1)−1.
- R5: A start accepted at clock edge E0 issues reads for tap k during cycle k+1. The matching write (tap k, `coef_waddr` = k) is visible during cycle k+3. Writes run one per cycle in ascending tap order, and no write appears in cycles 1 and 2.
- R6: `busy` is high in cycles 1 to M+2. `done` is a one-cycle pulse in cycle M+2, together with the write for tap M−1. All outputs return to idle in cycle M+3.
- R7: `start` is accepted only while `busy` is low. A start raised while busy, and any change of f, d or c after acceptance, has no effect on the pass in progress.
- R8: In each read cycle, `coef_raddr` equals the tap whose history sample is read. Each coefficient is written exactly once, two cycles after its read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request one update pass |
| offset_i | input | IW | History write offset f |
| delay_i | input | IW | Bulk delay d of the window, 0..N−M |
| step_err_i | input | SW | Signed scaled-error constant c |
| mem_rd_en | output | 1 | Read enable for both memories |
| hist_raddr | output | IW | History read address |
| hist_rdata | input | DW | Signed history sample, one cycle after the read |
| coef_raddr | output | TW | Coefficient read address |
| coef_rdata | input | CW | Signed coefficient, one cycle after the read |
| coef_we | output | 1 | Coefficient write strobe |
| coef_waddr | output | TW | Coefficient write address |
| coef_wdata | output | CW | Updated signed coefficient |
| busy | output | 1 | Pass in progress |
| done | output | 1 | Last write of the pass |

## Verification
The start is counted as accepted at the edge that samples it. The read addresses for tap k are due one cycle after that edge plus k. Its write is due two cycles after the read, because of the memory read register and the output register. `done` is due in cycle M+2. The bench samples at the falling edge of each counted cycle after the start, and in every such cycle it compares the read addresses, the write strobe, the write address, the data and `done` with values derived from the tap index. The bench sweeps every legal offset and delay with four step constants. It also injects stray starts, and checks the cycle after `done` for a return to idle.

// File: rtl/wlms_pkg.sv
package wlms_pkg;

   typedef enum logic [0:0] {
      SEQ_IDLE  = 1'b0,
      SEQ_ISSUE = 1'b1
   } seq_state_t;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/wlms_ring_idx.sv
module wlms_ring_idx #(
   parameter int N  = 16,
   parameter int IW = 4
) (
   input  logic [IW-1:0] f_i,
   input  logic [IW-1:0] d_i,
   input  logic [IW-1:0] cur_i,
   output logic [IW-1:0] start_o,
   output logic [IW-1:0] next_o
);
   localparam int SUMW = IW + 2;

   logic [SUMW-1:0] sum;

   always_comb begin
      sum = SUMW'(f_i) + SUMW'(N - 1) - SUMW'(d_i);
   end

   generate
      if (wlms_pkg::is_pow2(N)) begin : g_pow2
         // power-of-two depth: modulo is plain truncation
         assign start_o = sum[IW-1:0];
         assign next_o  = cur_i - IW'(1);
      end else begin : g_general
         assign start_o = (sum >= SUMW'(N)) ? IW'(sum - SUMW'(N)) : sum[IW-1:0];
         assign next_o  = (cur_i == '0) ? IW'(N - 1) : cur_i - IW'(1);
      end
   endgenerate

endmodule

// File: rtl/wlms_tap_seq.sv
module wlms_tap_seq #(
   parameter int M  = 6,
   parameter int TW = 3,
   parameter int IW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          busy_i,
   input  logic [IW-1:0] start_idx_i,
   input  logic [IW-1:0] next_idx_i,
   output logic          accept_o,
   output logic          issue_o,
   output logic          last_o,
   output logic [TW-1:0] tap_o,
   output logic [IW-1:0] idx_o
);
   import wlms_pkg::*;

   localparam logic [TW-1:0] LAST_TAP = TW'(M - 1);

   seq_state_t    state_q;
   logic [TW-1:0] tap_q;
   logic [IW-1:0] idx_q;

   assign accept_o = (state_q == SEQ_IDLE) && start_i && !busy_i;
   assign issue_o  = (state_q == SEQ_ISSUE);
   assign last_o   = issue_o && (tap_q == LAST_TAP);
   assign tap_o    = tap_q;
   assign idx_o    = idx_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         tap_q   <= '0;
         idx_q   <= '0;
      end else begin
         case (state_q)
            SEQ_IDLE: begin
               if (accept_o) begin
                  state_q <= SEQ_ISSUE;
                  tap_q   <= '0;
                  idx_q   <= start_idx_i;
               end
            end
            SEQ_ISSUE: begin
               idx_q <= next_idx_i;
               if (tap_q == LAST_TAP) begin
                  state_q <= SEQ_IDLE;
               end else begin
                  tap_q <= tap_q + TW'(1);
               end
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/wlms_mac_rnd.sv
module wlms_mac_rnd #(
   parameter int DW    = 16,
   parameter int CW    = 16,
   parameter int SW    = 16,
   parameter int FRAC  = 15,
   parameter int TW    = 3,
   parameter bit ROUND = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 vld_i,
   input  logic                 last_i,
   input  logic [TW-1:0]        tap_i,
   input  logic signed [DW-1:0] x_i,
   input  logic signed [CW-1:0] h_i,
   input  logic signed [SW-1:0] c_i,
   output logic                 pend_o,
   output logic                 we_o,
   output logic [TW-1:0]        waddr_o,
   output logic signed [CW-1:0] wdata_o,
   output logic                 done_o
);
   localparam int PW  = SW + DW;
   localparam int HW  = CW + FRAC;
   localparam int AW  = ((HW > PW) ? HW : PW) + 2;
   localparam logic signed [AW-1:0] MAXV = AW'((64'sd1 <<< (CW - 1)) - 64'sd1);
   localparam logic signed [AW-1:0] MINV = -MAXV - AW'(1);

   // alignment stage: memory data arrives one cycle after the read
   logic          vld_q;
   logic          last_q;
   logic [TW-1:0] tap_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q  <= 1'b0;
         last_q <= 1'b0;
         tap_q  <= '0;
      end else begin
         vld_q  <= vld_i;
         last_q <= last_i;
         tap_q  <= tap_i;
      end
   end

   logic signed [PW-1:0] prod;
   logic signed [AW-1:0] rnd;
   logic signed [AW-1:0] acc;
   logic signed [AW-1:0] shf;
   logic signed [CW-1:0] res;

   generate
      if (ROUND) begin : g_round
         assign rnd = AW'(1) <<< (FRAC - 1);
      end else begin : g_trunc
         assign rnd = '0;
      end
   endgenerate

   always_comb begin
      prod = c_i * x_i;
      acc  = (AW'(h_i) <<< FRAC) + AW'(prod) + rnd;
      shf  = acc >>> FRAC;
      if (shf > MAXV) begin
         res = MAXV[CW-1:0];
      end else if (shf < MINV) begin
         res = MINV[CW-1:0];
      end else begin
         res = shf[CW-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         we_o    <= 1'b0;
         waddr_o <= '0;
         wdata_o <= '0;
         done_o  <= 1'b0;
      end else begin
         we_o   <= vld_q;
         done_o <= vld_q && last_q;
         if (vld_q) begin
            waddr_o <= tap_q;
            wdata_o <= res;
         end
      end
   end

   assign pend_o = vld_q || we_o;

endmodule

// File: rtl/wlms_coef_update.sv
module wlms_coef_update #(
   parameter int N     = 16,
   parameter int M     = 6,
   parameter int DW    = 16,
   parameter int CW    = 16,
   parameter int SW    = 16,
   parameter int FRAC  = 15,
   parameter bit ROUND = 1'b1,
   localparam int IW   = (N > 1) ? $clog2(N) : 1,
   localparam int TW   = (M > 1) ? $clog2(M) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [IW-1:0]        offset_i,
   input  logic [IW-1:0]        delay_i,
   input  logic signed [SW-1:0] step_err_i,
   output logic                 mem_rd_en,
   output logic [IW-1:0]        hist_raddr,
   input  logic signed [DW-1:0] hist_rdata,
   output logic [TW-1:0]        coef_raddr,
   input  logic signed [CW-1:0] coef_rdata,
   output logic                 coef_we,
   output logic [TW-1:0]        coef_waddr,
   output logic signed [CW-1:0] coef_wdata,
   output logic                 busy,
   output logic                 done
);
   generate
      if (N < 2) begin : g_bad_n
         $error("wlms_coef_update: N must be at least 2");
      end
      if ((M < 2) || (M > N)) begin : g_bad_m
         $error("wlms_coef_update: M must lie in 2..N");
      end
      if ((FRAC < 1) || (FRAC >= SW + DW)) begin : g_bad_frac
         $error("wlms_coef_update: FRAC out of range");
      end
   endgenerate

   logic                 accept;
   logic                 issue;
   logic                 last;
   logic                 pend;
   logic [TW-1:0]        tap;
   logic [IW-1:0]        idx;
   logic [IW-1:0]        start_idx;
   logic [IW-1:0]        next_idx;
   logic signed [SW-1:0] c_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         c_q <= '0;
      end else if (accept) begin
         c_q <= step_err_i;
      end
   end

   wlms_ring_idx #(.N(N), .IW(IW)) u_idx (
      .f_i     (offset_i),
      .d_i     (delay_i),
      .cur_i   (idx),
      .start_o (start_idx),
      .next_o  (next_idx)
   );

   wlms_tap_seq #(.M(M), .TW(TW), .IW(IW)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start),
      .busy_i      (busy),
      .start_idx_i (start_idx),
      .next_idx_i  (next_idx),
      .accept_o    (accept),
      .issue_o     (issue),
      .last_o      (last),
      .tap_o       (tap),
      .idx_o       (idx)
   );

   wlms_mac_rnd #(
      .DW(DW), .CW(CW), .SW(SW), .FRAC(FRAC), .TW(TW), .ROUND(ROUND)
   ) u_mac (
      .clk     (clk),
      .rst_n   (rst_n),
      .vld_i   (issue),
      .last_i  (last),
      .tap_i   (tap),
      .x_i     (hist_rdata),
      .h_i     (coef_rdata),
      .c_i     (c_q),
      .pend_o  (pend),
      .we_o    (coef_we),
      .waddr_o (coef_waddr),
      .wdata_o (coef_wdata),
      .done_o  (done)
   );

   assign mem_rd_en  = issue;
   assign hist_raddr = idx;
   assign coef_raddr = tap;
   assign busy       = issue || pend;

endmodule

// File: rtl/wlms_chk.sv
module wlms_chk #(
   parameter int N  = 16,
   parameter int M  = 6,
   parameter int IW = 4,
   parameter int TW = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          mem_rd_en,
   input logic [IW-1:0] hist_raddr,
   input logic [TW-1:0] coef_raddr,
   input logic          coef_we,
   input logic [TW-1:0] coef_waddr,
   input logic          busy,
   input logic          done
);
   // R3
   hist_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_en && $past(mem_rd_en)) |->
         (hist_raddr == (($past(hist_raddr) == '0) ? IW'(N - 1) : $past(hist_raddr) - IW'(1))));

   // R8
   rd_wr_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      coef_we |-> ($past(mem_rd_en, 2) && (coef_waddr == $past(coef_raddr, 2))));

   // R6
   done_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (coef_we && (coef_waddr == TW'(M - 1))));

   // R6
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R5
   wr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (coef_we && (coef_waddr != TW'(M - 1))) |=>
         (coef_we && (coef_waddr == $past(coef_waddr) + TW'(1))));

   // R7
   fresh_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_rd_en) |-> ((coef_raddr == '0) && !$past(busy)));

endmodule

bind wlms_coef_update wlms_chk #(.N(N), .M(M), .IW(IW), .TW(TW)) u_wlms_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mem_rd_en  (mem_rd_en),
   .hist_raddr (hist_raddr),
   .coef_raddr (coef_raddr),
   .coef_we    (coef_we),
   .coef_waddr (coef_waddr),
   .busy       (busy),
   .done       (done)
);

// File: tb/test_wlms_coef_update.sv
`timescale 1ns/1ps
module test_wlms_coef_update;
   localparam int N    = 16;
   localparam int M    = 6;
   localparam int DW   = 16;
   localparam int CW   = 16;
   localparam int SW   = 16;
   localparam int FRAC = 15;
   localparam int IW   = 4;
   localparam int TW   = 3;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 start = 1'b0;
   logic [IW-1:0]        offset_i = '0;
   logic [IW-1:0]        delay_i = '0;
   logic signed [SW-1:0] step_err_i = '0;
   logic                 mem_rd_en;
   logic [IW-1:0]        hist_raddr;
   logic signed [DW-1:0] hist_rdata = '0;
   logic [TW-1:0]        coef_raddr;
   logic signed [CW-1:0] coef_rdata = '0;
   logic                 coef_we;
   logic [TW-1:0]        coef_waddr;
   logic signed [CW-1:0] coef_wdata;
   logic                 busy;
   logic                 done;

   int  nchk = 0;
   int  nerr = 0;
   int  sat_hits = 0;
   bit  finished = 1'b0;
   logic do_init = 1'b0;
   int  init_seed = 0;
   int  hist_seed = 0;
   logic signed [CW-1:0] coef_mem [M];

   always #4 clk = ~clk;

   wlms_coef_update #(
      .N(N), .M(M), .DW(DW), .CW(CW), .SW(SW), .FRAC(FRAC)
   ) i_wlms_coef_update (
      .clk(clk), .rst_n(rst_n), .start(start), .offset_i(offset_i),
      .delay_i(delay_i), .step_err_i(step_err_i), .mem_rd_en(mem_rd_en),
      .hist_raddr(hist_raddr), .hist_rdata(hist_rdata),
      .coef_raddr(coef_raddr), .coef_rdata(coef_rdata),
      .coef_we(coef_we), .coef_waddr(coef_waddr), .coef_wdata(coef_wdata),
      .busy(busy), .done(done)
   );

   function automatic logic signed [15:0] hist_val(int i, int s);
      int v;
      if (i == s % N) return 16'sh7fff;
      if (i == (s + 5) % N) return 16'sh8000;
      v = (i * 7919 + s * 1237) % 65536;
      return 16'(v - 32768);
   endfunction

   function automatic logic signed [15:0] init_coef(int k, int s);
      int v;
      if (k == s % M) return 16'sh7f00;
      if (k == (s + 3) % M) return 16'sh8100;
      v = (k * 4099 + s * 313) % 65536;
      return 16'(v - 32768);
   endfunction

   // memory model: one-cycle read latency, write on strobe
   always @(posedge clk) begin
      if (do_init) begin
         for (int k = 0; k < M; k++) coef_mem[k] <= init_coef(k, init_seed);
      end else if (coef_we) begin
         coef_mem[coef_waddr] <= coef_wdata;
      end
      if (mem_rd_en) begin
         hist_rdata <= hist_val(int'(hist_raddr), hist_seed);
         coef_rdata <= coef_mem[coef_raddr];
      end
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int hidx(int f, int d, int k);
      return ((f - d + N - 1 - k) % N + N) % N;
   endfunction

   task automatic run_pass(input int f, input int d, input int c, input int seed, input bit stray);
      int exp_w [M];
      longint p, r, s;
      @(negedge clk);
      do_init   = 1'b1;
      init_seed = seed;
      hist_seed = seed * 3;
      @(negedge clk);
      do_init = 1'b0;
      for (int k = 0; k < M; k++) begin
         p = longint'(c) * longint'(hist_val(hidx(f, d, k), hist_seed));
         r = (p + (64'sd1 <<< (FRAC - 1))) >>> FRAC;
         s = longint'(init_coef(k, seed)) + r;
         if (s > 32767) begin s = 32767; sat_hits++; end
         if (s < -32768) begin s = -32768; sat_hits++; end
         exp_w[k] = int'(s);
      end
      offset_i   = IW'(f);
      delay_i    = IW'(d);
      step_err_i = SW'(c);
      start      = 1'b1;
      for (int n = 1; n <= M + 2; n++) begin
         @(negedge clk);
         if (n == 1) start = 1'b0;
         if (stray && n == 2) begin
            start      = 1'b1;
            offset_i   = IW'(f ^ 5);
            delay_i    = '0;
            step_err_i = SW'(-c - 1);
         end
         if (stray && n == 3) start = 1'b0;
         chk(busy == 1'b1, "R6 busy", busy, 1);
         if (n <= M) begin
            // R3 R8: read addresses of tap n-1
            chk(mem_rd_en && hist_raddr == IW'(hidx(f, d, n - 1)) && coef_raddr == TW'(n - 1),
                "R3 R8 read address", hist_raddr, hidx(f, d, n - 1));
         end
         if (n >= 3) begin
            chk(coef_we && coef_waddr == TW'(n - 3), "R5 write slot", coef_waddr, n - 3);
            chk(coef_wdata == CW'(exp_w[n - 3]), stray ? "R7 result" : "R2 R4 result",
                coef_wdata, exp_w[n - 3]);
         end else begin
            chk(!coef_we, "R5 no early write", coef_we, 0);
         end
         chk(done == (n == M + 2), "R6 done", done, (n == M + 2));
      end
      @(negedge clk);
      chk(!busy && !done && !coef_we && !mem_rd_en, "R6 idle after pass", busy, 0);
   endtask

   initial begin
      int seed;
      int cs [4];
      cs[0] = 32767; cs[1] = -32768; cs[2] = 1234; cs[3] = -77;
      seed = 1;
      repeat (3) @(negedge clk);
      chk(!busy && !done && !coef_we && !mem_rd_en, "R1 reset state", busy, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && !coef_we && !mem_rd_en, "R1 idle after reset", busy, 0);
      for (int f = 0; f < N; f++) begin
         for (int d = 0; d <= N - M; d++) begin
            for (int ci = 0; ci < 4; ci++) begin
               run_pass(f, d, cs[ci], seed, ((f + d + ci) % 3) == 0);
               seed++;
            end
         end
      end
      chk(sat_hits > 0, "R4 saturation reached", sat_hits, 1);
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!finished) begin
         nchk++;
         nerr++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

endmodule